// File: doc/BRIEF.md
# Formatting UART Transmitter

This block takes data words of one or more bytes from a producer, queues them in an internal FIFO, and sends them out on an asynchronous serial line. The read side of the FIFO feeds a small formatter. The formatter splits each word into bytes in a selectable order and can rewrite them as text. It can pass bytes through untouched, keep only printable characters, or spell each byte as two uppercase hexadecimal digits, with or without a trailing space. After each word it can also add a fixed separator byte, and after the final word of a packet a fixed terminator byte.

The producer offers a word with `tx_en`. The word is taken in any cycle where `tx_rdy` is also high. Every option is an elaboration-time parameter: baud divider, parity, FIFO size, word width, byte order, text mode and the two trailer bytes. Formatting runs after the FIFO, so one FIFO entry costs one write cycle however many characters it expands into.

Top module: `fmt_uart_tx`

## Requirements
- R1: Each character is one frame: a low start bit, 8 data bits with the least significant bit first, the parity bit if enabled, then a high stop bit. Every bit lasts CLK_DIV clock cycles.
- R2: PARITY=0 sends no parity bit. PARITY=1 (odd) makes the count of ones across the data and parity bits odd. PARITY=2 (even) makes that count even.
- R3: A word and its last flag are taken exactly when tx_en and tx_rdy are both high. tx_rdy is low while the FIFO holds 2^ASIZE words. A word held until tx_rdy returns is sent exactly once, and no word is lost.
- R4: With BIG_ENDIAN=0, byte 0 (bits 7:0) of a word is sent first. With BIG_ENDIAN=1, the most significant byte is sent first.
- R5: MODE=0 sends every byte unchanged.
- R6: MODE=1 sends only bytes from 0x20 to 0x7E inclusive and silently drops all others.
- R7: MODE=2 sends each byte as two ASCII digits, high nibble first. Values 0–9 map to 0x30–0x39 and values 10–15 map to 0x41–0x46.
- R8: MODE=3 sends the two digits of R7 followed by a space (0x20).
- R9: With EOD_EN=1, the byte EOD_CHAR is sent unconverted after the last character of every word.
- R10: With EOP_EN=1, the byte EOP_CHAR is sent unconverted after a word written with tx_last=1. When both trailers apply, EOD_CHAR goes first.
- R11: During and right after reset, tx_line is high and tx_rdy is high.
- R12: Characters leave in the order the words were accepted, and the line stays high between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_data | input | DWIDTH*8 | Word offered by the producer |
| tx_last | input | 1 | Marks the word as the end of a packet |
| tx_en | input | 1 | Producer offers a word this cycle |
| tx_rdy | output | 1 | FIFO has room; a word offered now is taken |
| tx_line | output | 1 | Serial output, idle high |

## Verification
The bench runs four configurations at once and decodes each serial line with a behavioural receiver. It compares every byte against a queue of characters expanded from the accepted words. Several corner cases get targeted stimulus:
- The 0x7F value and control bytes are offered in printable mode. A filter with a wrong bound would leak them or drop the space character.
- Bytes with nibbles at 9/10 and 15 are offered in hex mode. An off-by-one in the digit map would print punctuation.
- Words carry the end-of-packet flag in a configuration that also has a per-word separator. Reversed trailer order or an ignored flag shows up as a mismatched byte.
- A burst is pushed into a four-entry FIFO while the line is busy. A ready signal that never drops, or a held word taken twice or not at all, would leave the receiver queue out of step.

// File: rtl/fmt_uart_tx.sv
module fmt_uart_tx #(
  parameter int CLK_DIV = 434,
  parameter int PARITY = 0,
  parameter int ASIZE = 6,
  parameter int DWIDTH = 1,
  parameter int BIG_ENDIAN = 0,
  parameter int MODE = 0,
  parameter int EOD_EN = 0,
  parameter logic [7:0] EOD_CHAR = 8'h0A,
  parameter int EOP_EN = 0,
  parameter logic [7:0] EOP_CHAR = 8'h0A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DWIDTH*8-1:0]   tx_data,
  input  logic                  tx_last,
  input  logic                  tx_en,
  output logic                  tx_rdy,
  output logic                  tx_line
);
  localparam int WW = DWIDTH * 8;
  localparam int DEPTH = 1 << ASIZE;
  localparam int IW = (DWIDTH > 1) ? $clog2(DWIDTH) : 1;
  localparam int BW = $clog2(CLK_DIV);
  localparam int NBITS = (PARITY == 0) ? 10 : 11;
  localparam logic [1:0] LASTPH = (MODE == 3) ? 2'd2 : ((MODE == 2) ? 2'd1 : 2'd0);
  localparam logic [IW-1:0] LASTB = IW'(DWIDTH - 1);
  localparam logic [BW-1:0] BAUD_TOP = BW'(CLK_DIV - 1);

  logic [WW:0] mem [DEPTH];
  logic [ASIZE:0] wptr, rptr;
  logic have, last, ser_busy;
  logic [WW-1:0] word;
  logic [IW-1:0] bidx, sel;
  logic [1:0] ph, stage;
  logic [7:0] ch;
  logic [10:0] shreg;
  logic [3:0] left;
  logic [BW-1:0] baud_cnt;

  wire empty = (wptr == rptr);
  wire full = (wptr[ASIZE] != rptr[ASIZE]) && (wptr[ASIZE-1:0] == rptr[ASIZE-1:0]);
  assign tx_rdy = !full;
  wire push = tx_en && !full;
  wire pop = !have && !empty;

  always_ff @(posedge clk)
    if (push) mem[wptr[ASIZE-1:0]] <= {tx_last, tx_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop) rptr <= rptr + 1'b1;
    end

  assign sel = (BIG_ENDIAN != 0) ? LASTB - bidx : bidx;
  wire [7:0] cur = word[{sel, 3'b000} +: 8];
  wire [3:0] nib = (ph == 2'd0) ? cur[7:4] : cur[3:0];
  wire [7:0] hexc = (nib < 4'd10) ? 8'h30 + {4'h0, nib} : 8'h37 + {4'h0, nib};

  always_comb begin
    case (stage)
      2'd1: ch = EOD_CHAR;
      2'd2: ch = EOP_CHAR;
      default: ch = (MODE >= 2) ? ((ph == 2'd2) ? 8'h20 : hexc) : cur;
    endcase
  end

  wire skip = (stage == 2'd0) && (MODE == 1) && (cur < 8'h20 || cur > 8'h7E);
  wire step = have && !ser_busy;
  wire load = step && !skip;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      have <= 1'b0;
      word <= '0;
      last <= 1'b0;
      bidx <= '0;
      ph <= 2'd0;
      stage <= 2'd0;
    end else if (pop) begin
      word <= mem[rptr[ASIZE-1:0]][WW-1:0];
      last <= mem[rptr[ASIZE-1:0]][WW];
      have <= 1'b1;
      bidx <= '0;
      ph <= 2'd0;
      stage <= 2'd0;
    end else if (step) begin
      if (stage == 2'd0) begin
        if (ph != LASTPH) ph <= ph + 1'b1;
        else begin
          ph <= 2'd0;
          if (bidx != LASTB) bidx <= bidx + 1'b1;
          else if (EOD_EN != 0) stage <= 2'd1;
          else if (EOP_EN != 0 && last) stage <= 2'd2;
          else have <= 1'b0;
        end
      end else if (stage == 2'd1 && EOP_EN != 0 && last) stage <= 2'd2;
      else have <= 1'b0;
    end

  wire parbit = (PARITY == 1) ? ~^ch : ^ch;
  wire [10:0] frame = {1'b1, (PARITY == 0) ? 1'b1 : parbit, ch, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ser_busy <= 1'b0;
      tx_line <= 1'b1;
      shreg <= '1;
      left <= '0;
      baud_cnt <= '0;
    end else if (load) begin
      shreg <= frame;
      left <= 4'(NBITS);
      baud_cnt <= BAUD_TOP;
      tx_line <= 1'b0;
      ser_busy <= 1'b1;
    end else if (ser_busy) begin
      if (baud_cnt != '0) baud_cnt <= baud_cnt - 1'b1;
      else if (left == 4'd1) begin
        ser_busy <= 1'b0;
        tx_line <= 1'b1;
      end else begin
        shreg <= {1'b1, shreg[10:1]};
        tx_line <= shreg[1];
        left <= left - 1'b1;
        baud_cnt <= BAUD_TOP;
      end
    end
endmodule

module fmt_uart_tx_chk #(
  parameter int BW = 4,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          tx_rdy,
  input logic          tx_line,
  input logic          ser_busy,
  input logic [BW-1:0] baud_cnt,
  input logic [AW-1:0] wptr
);
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ser_busy && baud_cnt != '0) |=> $stable(tx_line)); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(ser_busy) |-> !tx_line); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && !tx_rdy) |=> $stable(wptr)); // R3
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !ser_busy |-> tx_line); // R11
endmodule

bind fmt_uart_tx fmt_uart_tx_chk #(.BW(BW), .AW(ASIZE + 1)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_rdy(tx_rdy), .tx_line(tx_line),
  .ser_busy(ser_busy), .baud_cnt(baud_cnt), .wptr(wptr)
);

// File: tb/fmt_uart_tx_tb_top.sv
module fmt_uart_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] dat = '0;
  logic lst = 1'b0;
  logic [3:0] en = '0;
  wire [3:0] rdy, lines;
  int nchk = 0, nfail = 0;
  bit stalled = 0;
  logic [7:0] expq [4][$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fmt_uart_tx #(.CLK_DIV(DIV), .PARITY(2), .ASIZE(2), .DWIDTH(2), .BIG_ENDIAN(0), .MODE(0),
    .EOD_EN(1), .EOD_CHAR(8'h2C), .EOP_EN(1), .EOP_CHAR(8'h0A)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_data(dat), .tx_last(lst), .tx_en(en[0]),
    .tx_rdy(rdy[0]), .tx_line(lines[0]));
  fmt_uart_tx #(.CLK_DIV(DIV), .PARITY(1), .ASIZE(3), .DWIDTH(2), .BIG_ENDIAN(1), .MODE(3),
    .EOD_EN(0), .EOD_CHAR(8'h00), .EOP_EN(1), .EOP_CHAR(8'h0A)) dut_b (
    .clk(clk), .rst_n(rst_n), .tx_data(dat), .tx_last(lst), .tx_en(en[1]),
    .tx_rdy(rdy[1]), .tx_line(lines[1]));
  fmt_uart_tx #(.CLK_DIV(DIV), .PARITY(0), .ASIZE(3), .DWIDTH(2), .BIG_ENDIAN(0), .MODE(1),
    .EOD_EN(0), .EOD_CHAR(8'h00), .EOP_EN(1), .EOP_CHAR(8'h2E)) dut_c (
    .clk(clk), .rst_n(rst_n), .tx_data(dat), .tx_last(lst), .tx_en(en[2]),
    .tx_rdy(rdy[2]), .tx_line(lines[2]));
  fmt_uart_tx #(.CLK_DIV(DIV), .PARITY(0), .ASIZE(3), .DWIDTH(1), .BIG_ENDIAN(0), .MODE(2),
    .EOD_EN(1), .EOD_CHAR(8'h0A), .EOP_EN(1), .EOP_CHAR(8'h21)) dut_d (
    .clk(clk), .rst_n(rst_n), .tx_data(dat[7:0]), .tx_last(lst), .tx_en(en[3]),
    .tx_rdy(rdy[3]), .tx_line(lines[3]));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h41 + {4'h0, n} - 8'd10;
  endfunction

  function automatic string tagk(input int k);
    case (k)
      0: return "R4 R5 R9 R10 R12 inst0";
      1: return "R4 R8 R12 inst1";
      2: return "R6 R12 inst2";
      default: return "R7 R9 R10 R12 inst3";
    endcase
  endfunction

  task automatic model(input int k, input logic [15:0] d, input logic l);
    int nb, mode, big, eod, eop;
    logic [7:0] eodc, eopc;
    case (k)
      0: begin nb = 2; big = 0; mode = 0; eod = 1; eodc = 8'h2C; eop = 1; eopc = 8'h0A; end
      1: begin nb = 2; big = 1; mode = 3; eod = 0; eodc = 8'h00; eop = 1; eopc = 8'h0A; end
      2: begin nb = 2; big = 0; mode = 1; eod = 0; eodc = 8'h00; eop = 1; eopc = 8'h2E; end
      default: begin nb = 1; big = 0; mode = 2; eod = 1; eodc = 8'h0A; eop = 1; eopc = 8'h21; end
    endcase
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = d[8 * ((big != 0) ? nb - 1 - i : i) +: 8];
      if (mode == 0) expq[k].push_back(b);
      else if (mode == 1) begin
        if (b >= 8'h20 && b <= 8'h7E) expq[k].push_back(b);
      end else begin
        expq[k].push_back(hx(b[7:4]));
        expq[k].push_back(hx(b[3:0]));
        if (mode == 3) expq[k].push_back(8'h20);
      end
    end
    if (eod != 0) expq[k].push_back(eodc);
    if (eop != 0 && l) expq[k].push_back(eopc);
  endtask

  task automatic push(input logic [3:0] mask, input logic [15:0] d, input logic l);
    logic [3:0] pend, acc;
    pend = mask;
    while (pend != 0) begin
      @(negedge clk);
      dat = d;
      lst = l;
      en = pend;
      #1;
      acc = pend & rdy;
      if (acc != pend) stalled = 1;
      @(posedge clk);
      for (int k = 0; k < 4; k++) if (acc[k]) model(k, d, l);
      pend = pend & ~acc;
    end
    @(negedge clk);
    en = '0;
  endtask

  task automatic rx_mon(input int k, input int par);
    logic [7:0] b, e;
    logic p;
    forever begin
      do @(negedge clk); while (lines[k] !== 1'b0 || !rst_n);
      repeat (DIV / 2 - 1) @(negedge clk);
      chk(lines[k] == 1'b0, $sformatf("R1 start bit inst%0d", k), lines[k], 0);
      for (int i = 0; i < 8; i++) begin
        repeat (DIV) @(negedge clk);
        b[i] = lines[k];
      end
      if (par != 0) begin
        repeat (DIV) @(negedge clk);
        p = lines[k];
        chk((^{b, p}) == (par == 1), $sformatf("R2 parity inst%0d", k), p, 0);
      end
      repeat (DIV) @(negedge clk);
      chk(lines[k] == 1'b1, $sformatf("R1 stop bit inst%0d", k), lines[k], 1);
      if (expq[k].size() == 0) chk(0, $sformatf("R12 unexpected byte inst%0d", k), b, 0);
      else begin
        e = expq[k].pop_front();
        chk(b == e, tagk(k), b, e);
      end
    end
  endtask

  task automatic drain();
    int t = 0;
    while ((expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size()) != 0 && t < 60000) begin
      @(negedge clk);
      t++;
    end
    repeat (50) @(negedge clk);
  endtask

  initial rx_mon(0, 2);
  initial rx_mon(1, 1);
  initial rx_mon(2, 0);
  initial rx_mon(3, 0);

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(lines == 4'hF, "R11 line high in reset", lines, 4'hF);
    chk(rdy == 4'hF, "R11 ready in reset", rdy, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lines == 4'hF && rdy == 4'hF, "R11 idle after reset", {rdy, lines}, 8'hFF);
    push(4'hF, 16'h1234, 1'b0);
    push(4'hF, 16'h7F41, 1'b1);
    push(4'hF, 16'h0A20, 1'b0);
    push(4'hF, 16'hABCD, 1'b1);
    push(4'hF, 16'h00F9, 1'b0);
    push(4'hF, 16'h9E7E, 1'b1);
    drain();
    stalled = 0;
    for (int i = 0; i < 8; i++) push(4'h1, 16'h0130 + 16'(i), i == 7);
    chk(stalled, "R3 ready dropped when FIFO full", stalled, 1);
    drain();
    for (int k = 0; k < 4; k++)
      chk(expq[k].size() == 0, $sformatf("R3 R12 all bytes delivered inst%0d", k), expq[k].size(), 0);
    chk(lines == 4'hF, "R12 line idle at end", lines, 4'hF);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule